// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Controller

This block gathers eight interrupt request lines into sticky pending flags. It arbitrates between them only at instruction boundaries. When the core raises its instruction-end strobe, the controller registers the highest-priority source that is pending, unmasked and allowed by the global enable. It then holds an interrupt request toward the core together with that source's byte address in the jump table.

Each table slot is two bytes wide, so source n vectors to address 2*n. The core answers with an acknowledge, which clears the request, the winning source's pending flag and the global enable. The core raises the global enable again when it returns from the service routine.

Source 0 has the highest priority and source 7 the lowest. The default source map is: 0 reset, 1 fast timer tick, 2 slow timer tick, 3 control endpoint, 4 data endpoint, 5 unused, 6 pin-change, 7 wake-up. Slot 5 is hard-wired inactive.

Top module: `irq_vector_ctrl`

## Requirements
- R1: When several eligible sources are pending at a sampling point, the lowest-numbered one wins.
- R2: While `irq_o` is high, `vector_o` equals twice the winning source number (0x00 for source 0 up to 0x0E for source 7). While `irq_o` is low, `vector_o` reads 0.
- R3: `irq_o` rises only on the clock edge at which `instr_end_i` is high. Pending sources do not raise it while `instr_end_i` stays low.
- R4: Source 5 is reserved. A request on line 5 never produces an interrupt.
- R5: While `gie_o` is low, no request is issued, but requests still set their pending flags. They are serviced once the enable is restored.
- R6: An accepted acknowledge clears only the winning source's pending flag. Other pending sources are serviced later. A request arriving in the same cycle as the acknowledge of its own source is kept.
- R7: An accepted acknowledge clears `gie_o` on the following edge. `gie_set_i` sets it, and the acknowledge wins when both occur together.
- R8: Reset (`rst_ni` low) clears every pending flag, `gie_o`, `irq_o` and `vector_o`.
- R9: Once raised, `irq_o` and `vector_o` hold unchanged until an acknowledge, even if a higher-priority request and another instruction end arrive. An acknowledge while `irq_o` is low has no effect.
- R10: A source whose bit in `en_i` is low is not selected, but it stays pending and is serviced once enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Request lines; a high cycle sets the pending flag |
| en_i | input | 8 | Per-source enable mask |
| instr_end_i | input | 1 | High in the last clock cycle of an instruction |
| ack_i | input | 1 | Core acknowledge of the presented interrupt |
| gie_set_i | input | 1 | Return-from-interrupt: sets the global enable |
| gie_o | output | 1 | Global interrupt enable |
| irq_o | output | 1 | Interrupt request to the core |
| vector_o | output | 4 | Byte address of the winning slot |

## Verification
The hardest case to reach from the ports is a presented request that must stay frozen while the arbitration inputs change under it. To get there, the stimulus raises an interrupt, then injects a higher-priority request and another instruction end before the acknowledge. It checks that the vector does not move and that the newer source wins afterwards. A second hard case is the deferred service of flags built up while the global enable or a per-source mask was low. The stimulus reaches it by posting requests in that state, checking that the outputs stay idle, and only then re-enabling.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned NUM_SRC  = 8;
  localparam int unsigned IDX_W    = $clog2(NUM_SRC);
  localparam int unsigned VEC_W    = IDX_W + 1;
  localparam logic [NUM_SRC-1:0] RSV_MASK = 8'h20;

  function automatic logic [VEC_W-1:0] slot_addr(input logic [IDX_W-1:0] idx);
    return {idx, 1'b0};
  endfunction
endpackage

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
  parameter int unsigned N = 8,
  parameter logic [N-1:0] RSV = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    if (RSV[g]) begin : g_rsv
      assign pend_o[g] = 1'b0;
    end else begin : g_live
      logic pend_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       pend_q <= 1'b0;
        else if (set_i[g]) pend_q <= 1'b1;  // new request beats clear
        else if (clr_i[g]) pend_q <= 1'b0;
      end
      assign pend_o[g] = pend_q;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  cand_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_gie_ctrl.sv
module irq_gie_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic gie_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    gie_o <= 1'b0;
    else if (clr_i) gie_o <= 1'b0;
    else if (set_i) gie_o <= 1'b1;
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned N = NUM_SRC,
  parameter logic [N-1:0] RSV = RSV_MASK,
  localparam int unsigned IW = $clog2(N),
  localparam int unsigned VW = IW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  en_i,
  input  logic          instr_end_i,
  input  logic          ack_i,
  input  logic          gie_set_i,
  output logic          gie_o,
  output logic          irq_o,
  output logic [VW-1:0] vector_o
);
  logic [N-1:0]  pend;
  logic [N-1:0]  cand;
  logic [N-1:0]  clr;
  logic          win_vld;
  logic [IW-1:0] win_idx;
  logic          irq_q;
  logic [IW-1:0] sel_q;
  logic          ack_ok;
  logic          take;

  assign ack_ok = ack_i & irq_q;
  assign cand   = pend & en_i & ~RSV;
  assign take   = instr_end_i & gie_o & ~irq_q & win_vld;
  assign clr    = ack_ok ? (N'(1) << sel_q) : '0;

  irq_pending_bank #(.N(N), .RSV(RSV)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (req_i),
    .clr_i  (clr),
    .pend_o (pend)
  );

  irq_prio_enc #(.N(N)) u_enc (
    .cand_i  (cand),
    .valid_o (win_vld),
    .idx_o   (win_idx)
  );

  irq_gie_ctrl u_gie (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (gie_set_i),
    .clr_i  (ack_ok),
    .gie_o  (gie_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      sel_q <= '0;
    end else if (ack_ok) begin
      irq_q <= 1'b0;
    end else if (take) begin
      irq_q <= 1'b1;
      sel_q <= win_idx;
    end
  end

  assign irq_o    = irq_q;
  assign vector_o = irq_q ? {sel_q, 1'b0} : '0;
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int unsigned N = 8,
  parameter logic [N-1:0] RSV = '0,
  localparam int unsigned IW = $clog2(N),
  localparam int unsigned VW = IW + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          instr_end_i,
  input logic          ack_i,
  input logic          gie_set_i,
  input logic          gie_o,
  input logic          irq_o,
  input logic [VW-1:0] vector_o
);
  logic [IW-1:0] slot;
  assign slot = vector_o[VW-1:1];

  p_vec_even_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (vector_o[0] == 1'b0));
  p_idle_vec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (vector_o == '0));
  p_rise_on_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(instr_end_i) && $past(gie_o)));
  p_rsv_never_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !RSV[slot]);
  p_no_irq_wo_gie_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gie_o && !irq_o) |=> !irq_o);
  p_ack_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && ack_i) |=> (!gie_o && !irq_o));
  p_gie_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gie_set_i && !(irq_o && ack_i)) |=> gie_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_i) |=> (irq_o && $stable(vector_o)));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.N(N), .RSV(RSV)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .instr_end_i (instr_end_i),
  .ack_i       (ack_i),
  .gie_set_i   (gie_set_i),
  .gie_o       (gie_o),
  .irq_o       (irq_o),
  .vector_o    (vector_o)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] req_i = '0;
  logic [7:0] en_i = 8'hFF;
  logic       instr_end_i = 1'b0;
  logic       ack_i = 1'b0;
  logic       gie_set_i = 1'b0;
  logic       gie_o;
  logic       irq_o;
  logic [3:0] vector_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit seen = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_vector_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .en_i(en_i),
    .instr_end_i(instr_end_i), .ack_i(ack_i), .gie_set_i(gie_set_i),
    .gie_o(gie_o), .irq_o(irq_o), .vector_o(vector_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare each newly raised request against the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && irq_o && !seen) begin
      seen = 1;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected irq actual=%0h expected=none", vector_o);
      end else begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (vector_o !== e) begin
          errors++;
          $display("FAIL %s vector actual=%0h expected=%0h", t, vector_o, e);
        end
      end
    end
    if (!irq_o) seen = 0;
  end

  task automatic expect_vec(input int src, input string tag);
    exp_q.push_back(4'(2 * src));
    tag_q.push_back(tag);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic post(input logic [7:0] m);
    @(negedge clk_i) req_i = m;
    @(negedge clk_i) req_i = '0;
  endtask

  task automatic end_instr();
    @(negedge clk_i) instr_end_i = 1'b1;
    @(negedge clk_i) instr_end_i = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk_i) ack_i = 1'b1;
    @(negedge clk_i) ack_i = 1'b0;
  endtask

  task automatic set_gie();
    @(negedge clk_i) gie_set_i = 1'b1;
    @(negedge clk_i) gie_set_i = 1'b0;
  endtask

  task automatic serve(input int src, input string tag);
    set_gie();
    expect_vec(src, tag);
    end_instr();
    chk({tag, " irq"}, 8'(irq_o), 8'd1);
    do_ack();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    // R8 reset state
    chk("R8 irq", 8'(irq_o), 8'd0);
    chk("R8 gie", 8'(gie_o), 8'd0);
    chk("R8 vector", 8'(vector_o), 8'd0);
    rst_ni = 1'b1;
    cyc(2);

    // R5 accumulate with enable low
    post(8'h08);
    end_instr();
    cyc(2);
    chk("R5 no irq while gie low", 8'(irq_o), 8'd0);
    serve(3, "R5 deferred src3");
    chk("R7 gie cleared by ack", 8'(gie_o), 8'd0);
    chk("R2 idle vector", 8'(vector_o), 8'd0);

    // R3 no sampling without instruction end
    post(8'h04);
    set_gie();
    cyc(5);
    chk("R3 no irq before instr end", 8'(irq_o), 8'd0);
    expect_vec(2, "R3 src2");
    end_instr();
    do_ack();

    // R1 / R2 priority order
    post(8'hC6);
    serve(1, "R1 src1 first");
    serve(2, "R1 src2 second");
    serve(6, "R2 src6 addr 0x0C");
    serve(7, "R2 src7 addr 0x0E");
    post(8'h01);
    serve(0, "R2 src0 addr 0x00");

    // R4 reserved source
    post(8'h20);
    set_gie();
    end_instr();
    cyc(2);
    chk("R4 reserved no irq", 8'(irq_o), 8'd0);

    // R6 ack clears only winner; same-cycle request kept
    post(8'h0A);
    expect_vec(1, "R6 src1");
    end_instr();
    @(negedge clk_i) begin ack_i = 1'b1; req_i = 8'h02; end
    @(negedge clk_i) begin ack_i = 1'b0; req_i = 8'h00; end
    serve(1, "R6 src1 re-request kept");
    serve(3, "R6 src3 remains");

    // R9 hold under new higher request; ack while idle ignored
    post(8'h10);
    set_gie();
    expect_vec(4, "R9 src4");
    end_instr();
    post(8'h01);
    end_instr();
    chk("R9 vector held", 8'(vector_o), 8'h08);
    chk("R9 irq held", 8'(irq_o), 8'd1);
    do_ack();
    set_gie();
    do_ack();
    chk("R9 idle ack keeps gie", 8'(gie_o), 8'd1);
    expect_vec(0, "R9 src0 after hold");
    end_instr();
    do_ack();

    // R7 ack beats set
    post(8'h08);
    set_gie();
    expect_vec(3, "R7 src3");
    end_instr();
    @(negedge clk_i) begin ack_i = 1'b1; gie_set_i = 1'b1; end
    @(negedge clk_i) begin ack_i = 1'b0; gie_set_i = 1'b0; end
    chk("R7 ack wins over set", 8'(gie_o), 8'd0);

    // R10 per-source mask
    en_i = 8'hFB;
    post(8'h14);
    serve(4, "R10 masked src2 skipped");
    en_i = 8'hFF;
    serve(2, "R10 src2 after unmask");

    // R8 reset mid-run clears pending
    post(8'h40);
    set_gie();
    @(negedge clk_i) rst_ni = 1'b0;
    @(negedge clk_i) rst_ni = 1'b1;
    chk("R8 gie after reset", 8'(gie_o), 8'd0);
    set_gie();
    end_instr();
    cyc(2);
    chk("R8 pending cleared", 8'(irq_o), 8'd0);

    chk("scoreboard drained", 8'(exp_q.size()), 8'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule